// File: doc/BRIEF.md
# Rename-Stage Register Read Arbiter

This block sits at the rename stage of an out-of-order core. Each cycle it sees the head of the decode queue as a group of up to three micro-ops in slots 0 to 2. Each micro-op carries up to two source register numbers and an optional destination register with a completion tag. The block works out which distinct architectural registers the group really has to fetch from the committed register file. That file has only two read ports. The block issues those reads two per cycle and holds the group with a stall signal until the last pair has gone out. It accepts the group in that final cycle.

A register does not need a register-file read when an older micro-op that writes it is still in flight, because its value will reach the consumer through the reorder-buffer forwarding path. The same holds when an earlier slot of the same group writes it. The block keeps one pending bit and one tag per architectural register to track this. The bit is set when an accepted group writes the register. It is cleared only by a writeback notification that carries the matching tag. A mispredict flush aborts a group that is partly read, so that the next group starts its read sequence from the beginning.

Top module: `regread_arb`

## Requirements
- R1: A group that needs N register-file reads drives `grp_acc` in its ceil(N/2)-th cycle of presentation, counting the first cycle as 1, or in its first cycle when N is 0. `stall` is high in every earlier cycle and low in the accepting cycle.
- R2: A register named by several counted source operands of one group is read once only.
- R3: A destination is not a read. A micro-op whose `no_acct` bit is set neither reads (its sources are ignored) nor marks its destination pending.
- R4: When a group with a written destination is accepted, that register becomes pending from the next cycle. Pending registers cost no read. The set of reads is fixed by the pending state in the group's first cycle.
- R5: A writeback clears a register's pending bit only if `wb_tag` equals the tag of the youngest accepted writer of that register. A writeback with any other tag leaves the register pending.
- R6: A source is free when an earlier slot in the same group writes that register. A write from the same slot or a later slot does not make it free.
- R7: Reads are issued in operand order: slot 0 source 0, slot 0 source 1, slot 1 source 0, and so on. The k-th counted read goes out on port k mod 2 in cycle floor(k/2)+1. Port 1 is used only together with port 0. A port that is not enabled drives address 0.
- R8: In a cycle with `flush` high, `grp_acc`, `stall` and both read enables are low. The next group presented starts its read sequence again from the first read.
- R9: After reset, all outputs are low with no group present, and no register is pending.
- R10: Only slots whose `in_vld` bit is set count, and only sources whose `src_vld` bit is set count. `in_vld` is filled from slot 0 upward, so a partial group of one or two micro-ops is accepted like a full one.
- R11: With `in_vld` all zero there is no accept, no stall and no read enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| in_vld | input | 3 | Slot valid bits of the presented group, filled from slot 0 |
| no_acct | input | 3 | Per slot: micro-op is exempt from read accounting |
| src_vld | input | 6 | Source operand valid; bit 2*slot+i is source i of that slot |
| src_reg | input | 6*REGW | Source register numbers; operand k occupies bits [k*REGW +: REGW] |
| dst_vld | input | 3 | Per slot destination valid |
| dst_reg | input | 3*REGW | Destination register per slot |
| dst_tag | input | 3*TAGW | Completion tag per slot destination |
| wb_vld | input | 1 | Writeback notification valid |
| wb_reg | input | REGW | Register written back |
| wb_tag | input | TAGW | Tag of the writeback |
| flush | input | 1 | Mispredict flush; aborts the current group |
| grp_acc | output | 1 | Group accepted this cycle |
| stall | output | 1 | Group held this cycle for further reads |
| rd_en | output | 2 | Register-file read port enables |
| rd_addr | output | 2*REGW | Read addresses; port p at bits [p*REGW +: REGW] |

## Verification
`stall`, `grp_acc` and the read ports are combinational from the presented group and the registered sequencer phase. They are therefore due in the same cycle as the stimulus. Each later read pair is due one clock edge further on. A change in pending state from an accept or a writeback shows only in groups presented after the next rising edge. The bench drives every input just after a falling edge and samples one nanosecond later. It checks each cycle of a group against the port, stall and accept pattern predicted from the hand-counted read list. Pending effects are observed one group later through the number of reads that group needs.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int SLOTS = 3;
  localparam int SRCS  = 2;
  localparam int OPS   = SLOTS * SRCS;
  localparam int PORTS = 2;
  localparam int PHASES = (OPS + PORTS - 1) / PORTS;
  localparam int PHW   = $clog2(PHASES);
endpackage

// File: rtl/rra_need.sv
// Decides which source operands of the presented group need a register-file read.
module rra_need
  import rra_pkg::*;
#(
  parameter int NREG = 16,
  localparam int REGW = $clog2(NREG)
) (
  input  logic [SLOTS-1:0]      vld,
  input  logic [SLOTS-1:0]      noacct,
  input  logic [OPS-1:0]        src_vld,
  input  logic [OPS*REGW-1:0]   src_reg,
  input  logic [SLOTS-1:0]      dst_vld,
  input  logic [SLOTS*REGW-1:0] dst_reg,
  input  logic [NREG-1:0]       pend,
  output logic [OPS-1:0]        need
);

  logic [OPS-1:0] nd;
  logic           live;
  logic           free;
  logic           dup;

  always_comb begin
    nd   = '0;
    live = 1'b0;
    free = 1'b0;
    dup  = 1'b0;
    for (int k = 0; k < OPS; k++) begin
      live = vld[k/SRCS] & src_vld[k] & ~noacct[k/SRCS];
      free = pend[src_reg[k*REGW +: REGW]];
      for (int s = 0; s < k/SRCS; s++) begin
        if (vld[s] && dst_vld[s] && !noacct[s] &&
            dst_reg[s*REGW +: REGW] == src_reg[k*REGW +: REGW])
          free = 1'b1;
      end
      dup = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (nd[j] && src_reg[j*REGW +: REGW] == src_reg[k*REGW +: REGW])
          dup = 1'b1;
      end
      nd[k] = live & ~free & ~dup;
    end
  end

  assign need = nd;

endmodule

// File: rtl/rra_pend.sv
// Per-register in-flight bit and youngest-writer tag.
module rra_pend
  import rra_pkg::*;
#(
  parameter int NREG = 16,
  parameter int TAGW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [SLOTS-1:0]      vld,
  input  logic [SLOTS-1:0]      noacct,
  input  logic [SLOTS-1:0]      dst_vld,
  input  logic [SLOTS*REGW-1:0] dst_reg,
  input  logic [SLOTS*TAGW-1:0] dst_tag,
  input  logic                  wb_vld,
  input  logic [REGW-1:0]       wb_reg,
  input  logic [TAGW-1:0]       wb_tag,
  output logic [NREG-1:0]       pend
);

  logic [NREG-1:0] pend_q, pend_d;
  logic [TAGW-1:0] tag_q [NREG];
  logic [TAGW-1:0] tag_d [NREG];
  logic [NREG-1:0] tag_en;
  logic            wb_renew;

  always_comb begin
    pend_d   = pend_q;
    wb_renew = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      tag_d[r]  = tag_q[r];
      tag_en[r] = 1'b0;
      if (wb_vld && wb_reg == REGW'(r) && tag_q[r] == wb_tag)
        pend_d[r] = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        if (set_en && vld[s] && dst_vld[s] && !noacct[s] &&
            dst_reg[s*REGW +: REGW] == REGW'(r)) begin
          pend_d[r] = 1'b1;
          tag_d[r]  = dst_tag[s*TAGW +: TAGW];
          tag_en[r] = 1'b1;
          if (wb_reg == REGW'(r))
            wb_renew = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_tag
    always_ff @(posedge clk) begin
      if (tag_en[r]) tag_q[r] <= tag_d[r];
    end
  end

  assign pend = pend_q;

  // R5
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && pend_q[wb_reg] && tag_q[wb_reg] == wb_tag && !wb_renew)
      |=> !pend_q[$past(wb_reg)]);

  // R5
  wb_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && pend_q[wb_reg] && tag_q[wb_reg] != wb_tag)
      |=> pend_q[$past(wb_reg)]);

  // R4
  set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && vld[0] && dst_vld[0] && !noacct[0])
      |=> pend_q[$past(dst_reg[REGW-1:0])]);

endmodule

// File: rtl/rra_seq.sv
// Read-pair sequencer: issues counted reads two per cycle, stalls, accepts.
module rra_seq
  import rra_pkg::*;
#(
  parameter int REGW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   any_vld,
  input  logic                   flush,
  input  logic [OPS-1:0]         need_live,
  input  logic [OPS*REGW-1:0]    src_reg,
  output logic                   stall,
  output logic                   grp_acc,
  output logic [PORTS-1:0]       rd_en,
  output logic [PORTS*REGW-1:0]  rd_addr
);

  logic [PHW-1:0] phase_q, phase_d;
  logic [OPS-1:0] mask_q, mask_d, mask;
  logic           mask_en;
  logic           active;
  int             cnt;
  int             last;
  int             rank;

  assign active = any_vld & ~flush;

  always_comb begin
    mask = (phase_q == '0) ? need_live : mask_q;
    cnt  = 0;
    for (int k = 0; k < OPS; k++) cnt = cnt + int'(mask[k]);
    last = (cnt == 0) ? 0 : (cnt - 1) / PORTS;
  end

  assign grp_acc = active && (int'(phase_q) >= last);
  assign stall   = active && (int'(phase_q) <  last);

  always_comb begin
    rd_en   = '0;
    rd_addr = '0;
    rank    = 0;
    for (int k = 0; k < OPS; k++) begin
      if (mask[k]) begin
        for (int p = 0; p < PORTS; p++) begin
          if (active && rank == int'(phase_q) * PORTS + p) begin
            rd_en[p]                 = 1'b1;
            rd_addr[p*REGW +: REGW]  = src_reg[k*REGW +: REGW];
          end
        end
        rank = rank + 1;
      end
    end
  end

  always_comb begin
    phase_d = phase_q;
    mask_d  = need_live;
    mask_en = 1'b0;
    if (!active) begin
      phase_d = '0;
    end else if (stall) begin
      phase_d = phase_q + 1'b1;
      mask_en = (phase_q == '0);
    end else begin
      phase_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  // R1
  stall_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> phase_q == $past(phase_q) + 1'b1);

  // R1
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_acc |=> phase_q == '0);

  // R7
  port_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en[PORTS-1] |-> rd_en[0]);

  // R8
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> phase_q == '0);

endmodule

// File: rtl/regread_arb.sv
module regread_arb
  import rra_pkg::*;
#(
  parameter int NREG = 16,
  parameter int TAGW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       in_vld,
  input  logic [SLOTS-1:0]       no_acct,
  input  logic [OPS-1:0]         src_vld,
  input  logic [OPS*REGW-1:0]    src_reg,
  input  logic [SLOTS-1:0]       dst_vld,
  input  logic [SLOTS*REGW-1:0]  dst_reg,
  input  logic [SLOTS*TAGW-1:0]  dst_tag,
  input  logic                   wb_vld,
  input  logic [REGW-1:0]        wb_reg,
  input  logic [TAGW-1:0]        wb_tag,
  input  logic                   flush,
  output logic                   grp_acc,
  output logic                   stall,
  output logic [PORTS-1:0]       rd_en,
  output logic [PORTS*REGW-1:0]  rd_addr
);

  logic [1:0]      rsync_q;
  logic            rst_int_n;
  logic [NREG-1:0] pend;
  logic [OPS-1:0]  need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  rra_need #(.NREG(NREG)) u_need (
    .vld     (in_vld),
    .noacct  (no_acct),
    .src_vld (src_vld),
    .src_reg (src_reg),
    .dst_vld (dst_vld),
    .dst_reg (dst_reg),
    .pend    (pend),
    .need    (need)
  );

  rra_pend #(.NREG(NREG), .TAGW(TAGW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (grp_acc),
    .vld     (in_vld),
    .noacct  (no_acct),
    .dst_vld (dst_vld),
    .dst_reg (dst_reg),
    .dst_tag (dst_tag),
    .wb_vld  (wb_vld),
    .wb_reg  (wb_reg),
    .wb_tag  (wb_tag),
    .pend    (pend)
  );

  rra_seq #(.REGW(REGW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .any_vld   (|in_vld),
    .flush     (flush),
    .need_live (need),
    .src_reg   (src_reg),
    .stall     (stall),
    .grp_acc   (grp_acc),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld == '0) |-> (!stall && !grp_acc && rd_en == '0));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |-> (!stall && !grp_acc && rd_en == '0));

endmodule

// File: tb/regread_arb_test.sv
`timescale 1ns/1ps
module regread_arb_test;

  typedef struct packed {
    logic [2:0]  v;
    logic [2:0]  na;
    logic [5:0]  sv;
    logic [23:0] src;
    logic [2:0]  n;
    logic [23:0] exp;
  } vec_t;

  localparam int NROWS = 9;
  // R1 R2 R3 R10 read-pattern rows (no destinations)
  localparam vec_t TBL [NROWS] = '{
    '{3'b001, 3'b000, 6'b000011, 24'h000021, 3'd2, 24'h000021},
    '{3'b111, 3'b000, 6'b111111, 24'h654321, 3'd6, 24'h654321},
    '{3'b111, 3'b000, 6'b111111, 24'h377333, 3'd2, 24'h000073},
    '{3'b011, 3'b000, 6'b001111, 24'h00A898, 3'd3, 24'h000A98},
    '{3'b111, 3'b010, 6'b111111, 24'h514321, 3'd3, 24'h000521},
    '{3'b111, 3'b000, 6'b010101, 24'hBCFEDC, 3'd2, 24'h0000EC},
    '{3'b111, 3'b000, 6'b000000, 24'h123456, 3'd0, 24'h000000},
    '{3'b001, 3'b000, 6'b111111, 24'h543211, 3'd1, 24'h000001},
    '{3'b111, 3'b000, 6'b111111, 24'h043210, 3'd5, 24'h043210}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_vld, no_acct, dst_vld;
  logic [5:0]  src_vld;
  logic [23:0] src_reg;
  logic [11:0] dst_reg, dst_tag;
  logic        wb_vld;
  logic [3:0]  wb_reg, wb_tag;
  logic        flush;
  logic        grp_acc, stall;
  logic [1:0]  rd_en;
  logic [7:0]  rd_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  regread_arb uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .no_acct(no_acct),
    .src_vld(src_vld), .src_reg(src_reg), .dst_vld(dst_vld),
    .dst_reg(dst_reg), .dst_tag(dst_tag), .wb_vld(wb_vld),
    .wb_reg(wb_reg), .wb_tag(wb_tag), .flush(flush),
    .grp_acc(grp_acc), .stall(stall), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  function automatic string row_tag(int i);
    case (i)
      0: return "R1";
      1: return "R1";
      2: return "R2";
      3: return "R7";
      4: return "R3";
      5: return "R10";
      6: return "R1";
      7: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic idle_inputs();
    in_vld = '0; no_acct = '0; dst_vld = '0; src_vld = '0;
    src_reg = '0; dst_reg = '0; dst_tag = '0;
    wb_vld = 1'b0; wb_reg = '0; wb_tag = '0; flush = 1'b0;
  endtask

  // Present a group at a falling edge and check every cycle until acceptance.
  task automatic run_grp(input logic [2:0] v, input logic [2:0] na,
                         input logic [5:0] sv, input logic [23:0] src,
                         input logic [2:0] dv, input logic [11:0] dr,
                         input logic [11:0] dt, input int n,
                         input logic [23:0] ex, input string req);
    int cyc;
    bit ok;
    logic [11:0] act_v, exp_v, bad_a, bad_e;
    cyc = (n == 0) ? 1 : (n + 1) / 2;
    ok  = 1'b1;
    bad_a = '0; bad_e = '0;
    in_vld = v; no_acct = na; src_vld = sv; src_reg = src;
    dst_vld = dv; dst_reg = dr; dst_tag = dt;
    for (int c = 0; c < cyc; c++) begin
      #1;
      exp_v = '0;
      exp_v[11] = (c < cyc - 1);
      exp_v[10] = (c == cyc - 1);
      for (int p = 0; p < 2; p++) begin
        if (2*c + p < n) begin
          exp_v[8+p]     = 1'b1;
          exp_v[p*4 +: 4] = ex[(2*c+p)*4 +: 4];
        end
      end
      act_v = {stall, grp_acc, rd_en, rd_addr};
      if (act_v !== exp_v && ok) begin
        ok = 1'b0; bad_a = act_v; bad_e = exp_v;
      end
      @(posedge clk);
      @(negedge clk);
    end
    in_vld = '0; dst_vld = '0; src_vld = '0;
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s group reads=%0d: actual {stall,acc,en,addr}=%h expected %h",
               req, n, bad_a, bad_e);
    end
  endtask

  task automatic writeback(input logic [3:0] r, input logic [3:0] t);
    wb_vld = 1'b1; wb_reg = r; wb_tag = t;
    @(posedge clk);
    @(negedge clk);
    wb_vld = 1'b0;
  endtask

  task automatic check_quiet(input string req);
    #1;
    n_chk++;
    if (stall !== 1'b0 || grp_acc !== 1'b0 || rd_en !== 2'b00) begin
      n_fail++;
      $display("FAIL %s quiet outputs: actual stall=%b acc=%b en=%b expected 0 0 00",
               req, stall, grp_acc, rd_en);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 R11: outputs after reset with no group present
    check_quiet("R9");
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      run_grp(TBL[i].v, TBL[i].na, TBL[i].sv, TBL[i].src, 3'b000, 12'h0,
              12'h0, int'(TBL[i].n), TBL[i].exp, row_tag(i));
    end

    // R4: writer accepted, later reader of that register reads it free
    run_grp(3'b001, 3'b000, 6'b000000, 24'h0, 3'b001, 12'h005, 12'h003, 0, 24'h0, "R4");
    run_grp(3'b001, 3'b000, 6'b000011, 24'h000065, 3'b000, 12'h0, 12'h0, 1, 24'h000006, "R4");
    // R5: stale tag leaves reg 5 pending, matching tag clears it
    writeback(4'h5, 4'h2);
    run_grp(3'b001, 3'b000, 6'b000011, 24'h000065, 3'b000, 12'h0, 12'h0, 1, 24'h000006, "R5");
    writeback(4'h5, 4'h3);
    run_grp(3'b001, 3'b000, 6'b000011, 24'h000065, 3'b000, 12'h0, 12'h0, 2, 24'h000065, "R5");
    // R5: older writer's writeback does not clear a younger writer
    run_grp(3'b001, 3'b000, 6'b000000, 24'h0, 3'b001, 12'h007, 12'h001, 0, 24'h0, "R5");
    run_grp(3'b001, 3'b000, 6'b000000, 24'h0, 3'b001, 12'h007, 12'h002, 0, 24'h0, "R5");
    writeback(4'h7, 4'h1);
    run_grp(3'b001, 3'b000, 6'b000001, 24'h000007, 3'b000, 12'h0, 12'h0, 0, 24'h0, "R5");
    writeback(4'h7, 4'h2);
    run_grp(3'b001, 3'b000, 6'b000001, 24'h000007, 3'b000, 12'h0, 12'h0, 1, 24'h000007, "R5");
    // R6: slot 0 writes 9 (slot 1 read free), slot 2 writes 1 (slot 0 read still costs)
    run_grp(3'b111, 3'b000, 6'b010101, 24'h0B0901, 3'b101, 12'h109, 12'h504, 2, 24'h0000B1, "R6");
    // R3: exempt micro-op reads nothing and leaves its destination idle
    run_grp(3'b001, 3'b001, 6'b000011, 24'h0000ED, 3'b001, 12'h00D, 12'h006, 0, 24'h0, "R3");
    run_grp(3'b001, 3'b000, 6'b000001, 24'h00000D, 3'b000, 12'h0, 12'h0, 1, 24'h00000D, "R3");

    // R8: flush in the second cycle of a six-read group, then full restart
    in_vld = 3'b111; src_vld = 6'b111111; src_reg = 24'hC86432;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b1;
    check_quiet("R8");
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    run_grp(3'b111, 3'b000, 6'b111111, 24'hC86432, 3'b000, 12'h0, 12'h0, 6, 24'hC86432, "R8");

    // R11: idle cycle
    check_quiet("R11");
    @(negedge clk);

    // R9: reset clears pending regs 9 and 1 set by the R6 group
    do_reset();
    run_grp(3'b001, 3'b000, 6'b000011, 24'h000019, 3'b000, 12'h0, 12'h0, 2, 24'h000019, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule